// File: doc/BRIEF.md
# Two-Wire Bus Occupancy Watcher

This block listens passively to the data and clock lines of a shared two-wire bus and keeps track of whether another controller currently holds it. Each line first passes through a chain of synchronizing flops. Edges are then judged on the synchronized values. An open condition happens when data drops while the clock stays high. A close condition happens when data rises while the clock stays high. Two sticky status flags record which of the two conditions was seen last.

A local bus controller reads `bus_free` before it tries to take the bus. The watcher never drives either line. It runs regardless of what the local controller is doing, so it also follows traffic that other controllers generate. When the interrupt is enabled, each detected condition produces a one-cycle pulse. Software can therefore enable the interrupt while the bus is busy and learn from the next close condition that the bus has become available.

Top module: `i2c_bus_watch`

## Requirements
- R1: While reset is asserted and right after it is released, `start_seen`, `stop_seen` and `evt_irq` are 0 and `bus_free` is 1.
- R2: An open condition sets `start_seen` and clears `stop_seen`. An open condition is synchronized data going from 1 to 0 between two consecutive clock cycles while synchronized clock is 1 in both cycles.
- R3: A close condition sets `stop_seen` and clears `start_seen`. A close condition is synchronized data going from 0 to 1 between two consecutive clock cycles while synchronized clock is 1 in both cycles.
- R4: While `enable` is 0, both flags are 0 one cycle later and `evt_irq` stays 0, whatever the lines do.
- R5: `bus_free` is 1 exactly when `stop_seen` is 1 or both flags are 0.
- R6: `evt_irq` is a single-cycle pulse, raised together with the flag update for each detected condition when `enable` and `irq_enable` are both 1. It stays 0 when `irq_enable` is 0.
- R7: If `irq_enable` is raised while the bus is busy, the next close condition produces an `evt_irq` pulse and sets `bus_free`.
- R8: An open condition that occurs while `start_seen` is already 1 (a repeated open) pulses `evt_irq` and keeps `bus_free` at 0.
- R9: A line change reaches the flags three clock cycles after it is presented at the pins: two synchronizer stages plus one status register. A data change while the clock is low causes no event.
- R10: `start_seen` and `stop_seen` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Watcher enable. When low, it clears the flags and silences the interrupt |
| irq_enable | input | 1 | Lets detected conditions pulse `evt_irq` |
| sda_in | input | 1 | Bus data line as seen at the pin |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| start_seen | output | 1 | Sticky flag: an open condition was seen last |
| stop_seen | output | 1 | Sticky flag: a close condition was seen last |
| bus_free | output | 1 | The bus is free to be taken by a local controller |
| evt_irq | output | 1 | One-cycle pulse for each detected condition |

## Verification
The assertions assume that the pins are sampled on the watcher's clock and that `enable` and `irq_enable` change only between edges. They also assume that an open and a close condition never fall in the same synchronized cycle, which the detector makes impossible because each needs an opposite data edge. Stimulus is driven on the falling clock edge only. It mixes random line values, which often produce spurious conditions and edges while the clock is low, with directed sequences for an open, a repeated open, a close, and disabling mid-transfer. Because the random stream holds `enable` high most of the time, the sticky flags are exercised over long runs.

// File: rtl/bw_pkg.sv
package bw_pkg;

  // Synchronized view of both bus lines in one cycle
  typedef struct packed {
    logic sda;
    logic scl;
  } bw_lines_t;

  // Flag pair that the status register holds
  typedef struct packed {
    logic opened;
    logic closed;
  } bw_flags_t;

  // Open condition: data falls while clock high in both samples
  function automatic logic bw_is_open(bw_lines_t prev, bw_lines_t cur);
    return prev.scl & cur.scl & prev.sda & ~cur.sda;
  endfunction

  // Close condition: data rises while clock high in both samples
  function automatic logic bw_is_close(bw_lines_t prev, bw_lines_t cur);
    return prev.scl & cur.scl & ~prev.sda & cur.sda;
  endfunction

  // Availability rule for a local controller
  function automatic logic bw_free_of(bw_flags_t f);
    return f.closed | (~f.opened & ~f.closed);
  endfunction

  // Next flag state for a detected condition
  function automatic bw_flags_t bw_next_flags(bw_flags_t cur, logic op, logic cl);
    bw_flags_t n;
    n = cur;
    if (op) begin
      n.opened = 1'b1;
      n.closed = 1'b0;
    end else if (cl) begin
      n.opened = 1'b0;
      n.closed = 1'b1;
    end
    return n;
  endfunction

endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];

endmodule

// File: rtl/bw_cond_detect.sv
module bw_cond_detect
  import bw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  bw_lines_t lines,
  output logic      open_evt,
  output logic      close_evt
);

  bw_lines_t prev_q;

  // Previous synchronized sample; idle bus reads high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '{sda: 1'b1, scl: 1'b1};
    else        prev_q <= lines;
  end

  assign open_evt  = bw_is_open(prev_q, lines);
  assign close_evt = bw_is_close(prev_q, lines);

endmodule

// File: rtl/bw_status.sv
module bw_status
  import bw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      irq_enable,
  input  logic      open_evt,
  input  logic      close_evt,
  output bw_flags_t flags,
  output logic      irq
);

  bw_flags_t flags_q;
  logic      irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else if (!enable) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= bw_next_flags(flags_q, open_evt, close_evt);
      irq_q   <= irq_enable & (open_evt | close_evt);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
  import bw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic irq_enable,
  input  logic sda_in,
  input  logic scl_in,
  output logic start_seen,
  output logic stop_seen,
  output logic bus_free,
  output logic evt_irq
);

  localparam int LINE_W = $bits(bw_lines_t);

  logic [LINE_W-1:0] raw_lines;
  logic [LINE_W-1:0] sync_lines;
  bw_lines_t         lines_s;
  logic              open_evt;
  logic              close_evt;
  bw_flags_t         flags;

  assign raw_lines = {sda_in, scl_in};

  bw_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINE_W),
    .RST_VAL({LINE_W{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (raw_lines),
    .d_out(sync_lines)
  );

  assign lines_s = bw_lines_t'(sync_lines);

  bw_cond_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (lines_s),
    .open_evt (open_evt),
    .close_evt(close_evt)
  );

  bw_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .irq_enable(irq_enable),
    .open_evt  (open_evt),
    .close_evt (close_evt),
    .flags     (flags),
    .irq       (evt_irq)
  );

  assign start_seen = flags.opened;
  assign stop_seen  = flags.closed;
  assign bus_free   = bw_free_of(flags);

endmodule

// File: rtl/bw_checker.sv
module bw_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic irq_enable,
  input logic open_evt,
  input logic close_evt,
  input logic start_seen,
  input logic stop_seen,
  input logic bus_free,
  input logic evt_irq
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_seen && stop_seen));

  p_open_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && open_evt) |=> (start_seen && !stop_seen));

  p_close_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && close_evt) |=> (stop_seen && !start_seen));

  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_seen && !stop_seen && !evt_irq));

  p_busy_not_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_seen) |-> !bus_free);

  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && irq_enable && (open_evt || close_evt)) |=> evt_irq);

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_enable || !(open_evt || close_evt)) |=> !evt_irq);

  p_reopen_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && start_seen && open_evt) |=> (!bus_free && evt_irq == $past(irq_enable)));

endmodule

bind i2c_bus_watch bw_checker u_bw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .irq_enable(irq_enable),
  .open_evt  (open_evt),
  .close_evt (close_evt),
  .start_seen(start_seen),
  .stop_seen (stop_seen),
  .bus_free  (bus_free),
  .evt_irq   (evt_irq)
);

// File: tb/tb_i2c_bus_watch.sv
module tb_i2c_bus_watch;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic ien = 1'b0;
  logic sda = 1'b1;
  logic scl = 1'b1;
  logic s_o, p_o, free_o, irq_o;

  i2c_bus_watch dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en),
    .irq_enable(ien),
    .sda_in    (sda),
    .scl_in    (scl),
    .start_seen(s_o),
    .stop_seen (p_o),
    .bus_free  (free_o),
    .evt_irq   (irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // History of driven pin values: index 0 is the most recent drive
  logic hsda [4];
  logic hscl [4];
  logic m_s = 1'b0, m_p = 1'b0, m_irq = 1'b0;

  function automatic logic exp_free(logic s, logic p);
    return p || (!s && !p);
  endfunction

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
    end
  endtask

  // One cycle: check outputs for the state the model predicts, then drive new values
  task automatic step(input logic nsda, input logic nscl, input logic nen,
                      input logic nien, input string tag);
    logic op, cl;
    @(negedge clk);
    op = hscl[3] && hscl[2] && hsda[3] && !hsda[2];
    cl = hscl[3] && hscl[2] && !hsda[3] && hsda[2];
    if (!en) begin
      m_s = 1'b0; m_p = 1'b0; m_irq = 1'b0;
    end else begin
      if (op) begin m_s = 1'b1; m_p = 1'b0; end
      else if (cl) begin m_s = 1'b0; m_p = 1'b1; end
      m_irq = ien && (op || cl);
    end
    chk($sformatf("R2_R3 R9 start_seen [%s]", tag), s_o, m_s);
    chk($sformatf("R2_R3 R9 stop_seen [%s]", tag), p_o, m_p);
    chk($sformatf("R5 bus_free [%s]", tag), free_o, exp_free(m_s, m_p));
    chk($sformatf("R6 evt_irq [%s]", tag), irq_o, m_irq);
    chk($sformatf("R10 exclusive [%s]", tag), s_o && p_o, 1'b0);
    for (int i = 3; i > 0; i--) begin
      hsda[i] = hsda[i-1];
      hscl[i] = hscl[i-1];
    end
    hsda[0] = nsda; hscl[0] = nscl;
    sda = nsda; scl = nscl; en = nen; ien = nien;
  endtask

  task automatic hold(input logic nsda, input logic nscl, input int n, input string tag);
    for (int i = 0; i < n; i++) step(nsda, nscl, en, ien, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 4; i++) begin hsda[i] = 1'b1; hscl[i] = 1'b1; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 start_seen in reset", s_o, 1'b0);
    chk("R1 stop_seen in reset", p_o, 1'b0);
    chk("R1 bus_free in reset", free_o, 1'b1);
    chk("R1 evt_irq in reset", irq_o, 1'b0);
    rst_n = 1'b1;
    step(1, 1, 1, 1, "R1 after release");
    hold(1, 1, 4, "R1 idle");
    chk("R1 bus_free idle after reset", free_o, 1'b1);

    // Open condition, latency check
    step(0, 1, 1, 1, "R2 open");
    hold(0, 1, 2, "R9 latency");
    chk("R9 start not yet visible", s_o, 1'b0);
    hold(0, 1, 1, "R2 open seen");
    chk("R2 start_seen set", s_o, 1'b1);
    chk("R6 irq pulse on open", irq_o, 1'b1);
    hold(0, 1, 1, "R6 single pulse");
    chk("R6 irq gone after one cycle", irq_o, 1'b0);

    // Data toggles while clock low: no events
    hold(0, 0, 3, "R9 clk low");
    hold(1, 0, 3, "R9 data high clk low");
    hold(0, 0, 3, "R9 data low clk low");
    chk("R9 no event while clock low", s_o, 1'b1);

    // Repeated open
    hold(1, 0, 2, "R8 prep");
    hold(1, 1, 2, "R8 prep");
    hold(0, 1, 3, "R8 reopen");
    hold(0, 1, 1, "R8 reopen seen");
    chk("R8 repeated open keeps bus busy", free_o, 1'b0);
    chk("R8 repeated open pulses irq", irq_o, 1'b1);

    // Irq disabled, then enabled while busy, then close
    step(0, 0, 1, 0, "R7 irq off");
    hold(0, 0, 4, "R7 busy");
    step(0, 1, 1, 1, "R7 irq on while busy");
    hold(0, 1, 3, "R7 busy");
    chk("R7 still busy", free_o, 1'b0);
    hold(1, 1, 3, "R7 close");
    hold(1, 1, 1, "R7 close seen");
    chk("R7 irq on close", irq_o, 1'b1);
    chk("R7 bus free after close", free_o, 1'b1);

    // Open with irq disabled
    step(0, 1, 1, 0, "R6 quiet open");
    hold(0, 1, 4, "R6 quiet");
    chk("R6 quiet open sets flag", s_o, 1'b1);

    // Disable mid-transfer
    step(0, 1, 0, 1, "R4 disable");
    hold(0, 1, 2, "R4 disabled");
    chk("R4 flags cleared", s_o | p_o, 1'b0);
    hold(1, 1, 4, "R4 close ignored");
    chk("R4 no irq while disabled", irq_o, 1'b0);
    chk("R4 bus free while disabled", free_o, 1'b1);
    step(1, 1, 1, 1, "R4 reenable");
    hold(1, 1, 4, "R4 idle");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic rs, rc, re, ri;
      rs = ($urandom % 3 == 0) ? ~sda : sda;
      rc = ($urandom % 3 == 0) ? ~scl : scl;
      re = ($urandom % 20) != 0;
      ri = ($urandom % 4) != 0;
      step(rs, rc, re, ri, "random");
    end
    hold(1, 1, 6, "drain");

    done = 1;
    summary();
    $finish;
  end

endmodule